// File: doc/BRIEF.md
# Repeated-Trace Coherent Averager

This block improves the signal-to-noise ratio of fiber backscatter measurements by averaging many traces taken with the same timing. Each laser pulse is followed by a trace of samples on two 8-bit channels, Stokes and anti-Stokes. Samples are counted from the pulse trigger, so a given sample index (range bin) always maps to the same distance along the fiber. For every bin, the block adds up that bin's sample from K successive traces, keeping a separate sum for each channel. It then divides by K to give the averaged trace. On uncorrelated noise the averaged trace gains a factor of sqrt(K) in SNR, so K sets the balance between measurement time and noise.

K is chosen at run time as 2^n, with n from 0 to 10, so the final divide is a rounded right shift. Each incoming trace is first held in a staging buffer. It is added into the per-bin sums only when it has arrived complete, so a trace that is cut short leaves the sums untouched. When the K-th trace has been added, a done flag rises. The averaged bins then leave on a valid/ready stream, ready for a slow readout path such as a serial link.

Top module: `trace_averager`

## Requirements
- R1: After reset, `m_valid`, `done` and `trace_err` are 0, and `trig` and samples are ignored until a `start` pulse arrives.
- R2: A `start` pulse accepted while the block is idle or waiting for a trigger clears the trace count and `trace_err`, and latches n from `log_k`. Values of `log_k` above 10 are taken as 10. A `start` pulse during capture, accumulation or readout has no effect.
- R3: While the block waits for a trigger, `trig` begins a new trace. Every cycle in which `s_valid` is high then supplies the next bin, counting from 0. Idle cycles between samples are allowed. `trig` has no effect while a trace is being captured.
- R4: A trace is complete after N_BINS valid samples. Each bin keeps its own sum for the Stokes channel and for the anti-Stokes channel, and each complete trace adds exactly one sample to each of these sums.
- R5: If `s_end` is seen before N_BINS samples have arrived, `trace_err` is set. The flag stays set until the next accepted `start`, and that trace is not counted toward K and does not change any sum.
- R6: `done` rises once K = 2^n complete traces have been added, and not before. Each averaged value is (sum + 2^(n-1)) >> n for n > 0, and the sum itself for n = 0.
- R7: When `done` is high, 2*N_BINS averaged values stream out: the Stokes channel bins 0..N_BINS-1 first, then the anti-Stokes channel bins 0..N_BINS-1. `m_valid` is high only while `done` is high.
- R8: While `m_valid` is high and `m_ready` is low, `m_valid` stays high and `m_data` does not change.
- R9: While `done` is high, `trig` and samples are ignored. After the last value has been accepted, `done` falls and the block returns to idle, where it needs a new `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begins a new averaging run |
| log_k | input | $clog2(MAX_LOGK+1) (4) | n, where K = 2^n, sampled on start |
| trig | input | 1 | Pulse trigger that begins a trace |
| s_valid | input | 1 | Sample pair valid |
| s_stokes | input | W (8) | Stokes channel sample |
| s_anti | input | W (8) | Anti-Stokes channel sample |
| s_end | input | 1 | Front end marks the end of its trace |
| m_ready | input | 1 | Downstream accepts the output value |
| m_valid | output | 1 | Output value valid |
| m_data | output | W (8) | Averaged bin value |
| done | output | 1 | Averaging complete, readout in progress |
| trace_err | output | 1 | Sticky flag for a trace that was cut short |

## Verification
The bench targets the following corner cases and the failure each one would expose:
- A trace cut short part-way through. A design that wrote samples straight into the sums would leave those partial samples in the first bins, and the averages would drift away from the model.
- A stray trigger in the middle of a trace. If the trigger restarted capture, the bin numbering would shift.
- A `start` in the middle of a trace. If it were accepted, it would change K and reset the trace count, so `done` would arrive on the wrong trace.
- Idle gaps in `s_valid`. A design that counted cycles instead of valid samples would put samples in the wrong bins.
- Back-pressure from `m_ready`, which exposes lost or repeated output values.
- K=1, where no rounding offset may be added.
- K=1024 with every sample at full scale, which exposes a sum that is too narrow or a rounding step that overflows.
- An oversized `log_k`, which shows whether the clamp to n=10 is in place.

// File: rtl/avg_pkg.sv
package avg_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ARMED,
    ST_CAPT,
    ST_COMMIT,
    ST_RREQ,
    ST_RLOAD,
    ST_RHOLD
  } avg_state_t;
endpackage

// File: rtl/avg_sdp_ram.sv
module avg_sdp_ram #(
  parameter int DW    = 16,
  parameter int DEPTH = 1024,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/avg_round.sv
module avg_round #(
  parameter int W     = 8,
  parameter int ACC_W = 18,
  parameter int SHW   = 4
) (
  input  logic [ACC_W-1:0] sum,
  input  logic [SHW-1:0]   shift,
  output logic [W-1:0]     avg
);
  logic [ACC_W:0] half;
  logic [ACC_W:0] tot;

  always_comb begin
    half = '0;
    if (shift != '0) half = (ACC_W+1)'(1) << (shift - SHW'(1));
    tot = {1'b0, sum} + half;
    avg = W'(tot >> shift);
  end
endmodule

// File: rtl/trace_averager.sv
module trace_averager
  import avg_pkg::*;
#(
  parameter int W        = 8,
  parameter int N_BINS   = 1024,
  parameter int MAX_LOGK = 10,
  localparam int LW      = $clog2(MAX_LOGK + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [LW-1:0] log_k,
  input  logic          trig,
  input  logic          s_valid,
  input  logic [W-1:0]  s_stokes,
  input  logic [W-1:0]  s_anti,
  input  logic          s_end,
  input  logic          m_ready,
  output logic          m_valid,
  output logic [W-1:0]  m_data,
  output logic          done,
  output logic          trace_err
);
  localparam int AW    = $clog2(N_BINS);
  localparam int ACC_W = W + MAX_LOGK;
  localparam int KW    = MAX_LOGK + 1;
  localparam logic [AW-1:0] LAST_BIN = AW'(N_BINS - 1);

  avg_state_t st;
  logic [LW-1:0]      shift_q, lk_cl;
  logic [KW-1:0]      rep_cnt, k_val;
  logic [AW-1:0]      bin_cnt, ca, ca_d;
  logic               issue_done, cv, rch;
  logic               commit_issue, first;
  logic [2*W-1:0]     stg_rd;
  logic [2*ACC_W-1:0] acc_rd, acc_wr;
  logic [ACC_W-1:0]   acc_lo, acc_hi;
  logic [W-1:0]       avg_out;

  assign lk_cl        = (log_k > LW'(MAX_LOGK)) ? LW'(MAX_LOGK) : log_k;
  assign k_val        = KW'(1) << shift_q;
  assign commit_issue = (st == ST_COMMIT) && !issue_done;
  assign first        = (rep_cnt == '0);

  // Staging buffer: one full trace, both channels packed per bin
  avg_sdp_ram #(.DW(2*W), .DEPTH(N_BINS)) u_stage (
    .clk   (clk),
    .we    ((st == ST_CAPT) && s_valid),
    .waddr (bin_cnt),
    .wdata ({s_anti, s_stokes}),
    .re    (commit_issue),
    .raddr (ca),
    .rdata (stg_rd)
  );

  // Per-bin accumulator update, first committed trace overwrites
  always_comb begin
    acc_lo = (first ? '0 : acc_rd[ACC_W-1:0])       + ACC_W'(stg_rd[W-1:0]);
    acc_hi = (first ? '0 : acc_rd[2*ACC_W-1:ACC_W]) + ACC_W'(stg_rd[2*W-1:W]);
    acc_wr = {acc_hi, acc_lo};
  end

  avg_sdp_ram #(.DW(2*ACC_W), .DEPTH(N_BINS)) u_acc (
    .clk   (clk),
    .we    (cv),
    .waddr (ca_d),
    .wdata (acc_wr),
    .re    (commit_issue || (st == ST_RREQ)),
    .raddr ((st == ST_COMMIT) ? ca : bin_cnt),
    .rdata (acc_rd)
  );

  avg_round #(.W(W), .ACC_W(ACC_W), .SHW(LW)) u_round (
    .sum   (rch ? acc_rd[2*ACC_W-1:ACC_W] : acc_rd[ACC_W-1:0]),
    .shift (shift_q),
    .avg   (avg_out)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_IDLE;
      shift_q    <= '0;
      rep_cnt    <= '0;
      bin_cnt    <= '0;
      ca         <= '0;
      ca_d       <= '0;
      issue_done <= 1'b0;
      cv         <= 1'b0;
      rch        <= 1'b0;
      m_valid    <= 1'b0;
      m_data     <= '0;
      done       <= 1'b0;
      trace_err  <= 1'b0;
    end else begin
      cv   <= commit_issue;
      ca_d <= ca;
      case (st)
        ST_IDLE, ST_ARMED: begin
          if (start) begin
            shift_q   <= lk_cl;
            rep_cnt   <= '0;
            trace_err <= 1'b0;
            st        <= ST_ARMED;
          end else if (st == ST_ARMED && trig) begin
            bin_cnt <= '0;
            st      <= ST_CAPT;
          end
        end
        ST_CAPT: begin
          if (s_valid && bin_cnt == LAST_BIN) begin
            bin_cnt    <= '0;
            ca         <= '0;
            issue_done <= 1'b0;
            st         <= ST_COMMIT;
          end else begin
            if (s_valid) bin_cnt <= bin_cnt + AW'(1);
            if (s_end) begin
              trace_err <= 1'b1;
              st        <= ST_ARMED;
            end
          end
        end
        ST_COMMIT: begin
          if (commit_issue) begin
            if (ca == LAST_BIN) issue_done <= 1'b1;
            else                ca <= ca + AW'(1);
          end
          if (cv && ca_d == LAST_BIN) begin
            rep_cnt <= rep_cnt + KW'(1);
            if (rep_cnt + KW'(1) == k_val) begin
              done    <= 1'b1;
              bin_cnt <= '0;
              rch     <= 1'b0;
              st      <= ST_RREQ;
            end else begin
              st <= ST_ARMED;
            end
          end
        end
        ST_RREQ: st <= ST_RLOAD;
        ST_RLOAD: begin
          m_data  <= avg_out;
          m_valid <= 1'b1;
          st      <= ST_RHOLD;
        end
        ST_RHOLD: begin
          if (m_ready) begin
            m_valid <= 1'b0;
            st      <= ST_RREQ;
            if (bin_cnt == LAST_BIN) begin
              bin_cnt <= '0;
              if (rch) begin
                done <= 1'b0;
                st   <= ST_IDLE;
              end else begin
                rch <= 1'b1;
              end
            end else begin
              bin_cnt <= bin_cnt + AW'(1);
            end
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // Checks beside the logic they guard
  p_trig_ignored_r3: assert property (@(posedge clk) disable iff (rst)
    (st == ST_CAPT && !s_valid && !s_end) |=> (st == ST_CAPT && $stable(bin_cnt)));

  p_err_sticky_r5: assert property (@(posedge clk) disable iff (rst)
    (trace_err && !start) |=> trace_err);

  p_rep_bound_r6: assert property (@(posedge clk) disable iff (rst)
    rep_cnt <= k_val);

  p_stream_in_done_r7: assert property (@(posedge clk) disable iff (rst)
    m_valid |-> done);

  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_data)));

  p_done_idle_r9: assert property (@(posedge clk) disable iff (rst)
    $fell(done) |-> (st == ST_IDLE));
endmodule

// File: tb/tb_trace_averager.sv
module tb_trace_averager;
  localparam int NB = 32;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start = 1'b0;
  logic [3:0] log_k = '0;
  logic       trig = 1'b0;
  logic       s_valid = 1'b0;
  logic [7:0] s_stokes = '0;
  logic [7:0] s_anti = '0;
  logic       s_end = 1'b0;
  logic       m_ready = 1'b0;
  logic       m_valid;
  logic [7:0] m_data;
  logic       done;
  logic       trace_err;

  always #2.5 clk = ~clk;

  trace_averager #(.W(8), .N_BINS(NB), .MAX_LOGK(10)) dut (
    .clk(clk), .rst(rst), .start(start), .log_k(log_k), .trig(trig),
    .s_valid(s_valid), .s_stokes(s_stokes), .s_anti(s_anti), .s_end(s_end),
    .m_ready(m_ready), .m_valid(m_valid), .m_data(m_data),
    .done(done), .trace_err(trace_err)
  );

  int total = 0;
  int fails = 0;
  int unsigned seed = 32'h1234_5678;
  int sum0 [NB];
  int sum1 [NB];
  int kk = 1;
  int nsh = 0;
  int cnt = 0;
  bit err_m = 1'b0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", total - fails, total);
  endtask

  function automatic logic [7:0] nxt();
    seed = seed * 32'd1103515245 + 32'd12345;
    return seed[23:16];
  endfunction

  function automatic int rnd(input int s, input int n);
    if (n == 0) return s;
    return (s + (1 << (n - 1))) >> n;
  endfunction

  task automatic do_start(input int n);
    @(negedge clk);
    start = 1'b1;
    log_k = 4'(n);
    @(negedge clk);
    start = 1'b0;
    nsh = (n > 10) ? 10 : n;
    kk = 1 << nsh;
    cnt = 0;
    err_m = 1'b0;
    foreach (sum0[j]) begin sum0[j] = 0; sum1[j] = 0; end
  endtask

  // One trace; model updated only when complete and expected to count
  task automatic do_trace(input int len, input bit gaps, input bit poke_trig,
                          input bit poke_start, input bit maxval, input bit counted);
    int b0 [NB];
    int b1 [NB];
    @(negedge clk);
    trig = 1'b1;
    @(negedge clk);
    trig = 1'b0;
    for (int j = 0; j < len; j++) begin
      if (gaps && (j % 5 == 2)) begin
        s_valid = 1'b0;
        @(negedge clk);
      end
      s_valid  = 1'b1;
      s_stokes = maxval ? 8'hFF : nxt();
      s_anti   = maxval ? 8'hFF : nxt();
      b0[j] = int'(s_stokes);
      b1[j] = int'(s_anti);
      s_end = (len < NB) && (j == len - 1);
      trig  = poke_trig && (j == 3);
      if (poke_start && j == 5) begin
        start = 1'b1;
        log_k = 4'd0;
      end
      @(negedge clk);
      start = 1'b0;
      trig  = 1'b0;
      s_end = 1'b0;
    end
    s_valid = 1'b0;
    if (counted && len == NB) begin
      for (int j = 0; j < NB; j++) begin
        sum0[j] += b0[j];
        sum1[j] += b1[j];
      end
      cnt++;
    end else if (counted) begin
      err_m = 1'b1;
    end
    repeat (NB + 6) @(negedge clk);
  endtask

  task automatic readout(input bit random_ready);
    int beat = 0;
    bit pv = 1'b0;
    bit pr = 1'b0;
    logic [7:0] pd = '0;
    int exp;
    while (beat < 2 * NB) begin
      @(negedge clk);
      if (pv && !pr) begin
        check(m_valid === 1'b1, "R8 valid held", int'(m_valid), 1);
        check(m_data === pd, "R8 data stable", int'(m_data), int'(pd));
      end
      m_ready = random_ready ? nxt()[0] : 1'b1;
      if (m_valid && m_ready) begin
        exp = (beat < NB) ? rnd(sum0[beat], nsh) : rnd(sum1[beat - NB], nsh);
        check(int'(m_data) == exp, "R7 R6 R4 averaged bin", int'(m_data), exp);
        beat++;
      end
      pv = m_valid;
      pr = m_ready;
      pd = m_data;
    end
    @(negedge clk);
    m_ready = 1'b0;
    repeat (4) @(negedge clk);
    check(done === 1'b0, "R9 done falls after readout", int'(done), 0);
    check(m_valid === 1'b0, "R9 no extra beats", int'(m_valid), 0);
  endtask

  task automatic after_trace_checks();
    check(trace_err === err_m, "R5 trace_err", int'(trace_err), int'(err_m));
    check(done === (cnt == kk), "R6 done timing", int'(done), int'(cnt == kk));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    summary();
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(m_valid === 1'b0, "R1 m_valid reset", int'(m_valid), 0);
    check(done === 1'b0, "R1 done reset", int'(done), 0);
    check(trace_err === 1'b0, "R1 err reset", int'(trace_err), 0);
    do_trace(NB, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    check(done === 1'b0, "R1 trig before start ignored", int'(done), 0);
    check(m_valid === 1'b0, "R1 no output before start", int'(m_valid), 0);

    // K=1
    do_start(0);
    do_trace(NB, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1);
    after_trace_checks();
    readout(1'b0);
    // R9: triggers after readout need a new start
    do_trace(NB, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    check(done === 1'b0, "R9 idle ignores trig", int'(done), 0);

    // K=4 with stray trigger, short trace, mid-trace start
    do_start(2);
    do_trace(NB, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1);   // R3 stray trig
    after_trace_checks();
    do_trace(10, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);   // R5 short trace
    after_trace_checks();
    do_trace(NB, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1);   // R2 start ignored
    after_trace_checks();
    do_trace(NB, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1);
    after_trace_checks();
    do_trace(NB, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    after_trace_checks();
    do_trace(NB, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);   // R9 ignored while done
    check(done === 1'b1, "R9 done holds", int'(done), 1);
    readout(1'b1);

    // K=8, R2 start clears error
    do_start(3);
    check(trace_err === 1'b0, "R2 start clears err", int'(trace_err), 0);
    for (int t = 0; t < 8; t++) begin
      do_trace(NB, t[0], 1'b0, 1'b0, 1'b0, 1'b1);
      after_trace_checks();
    end
    readout(1'b1);

    // log_k 15 clamps to 10, full-scale samples
    do_start(15);
    for (int t = 0; t < 1024; t++) begin
      do_trace(NB, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1);
      after_trace_checks();
    end
    readout(1'b0);

    summary();
    $finish;
  end
endmodule